// File: doc/BRIEF.md
# Repeater Expansion Bus Controller

This block ties one repeater slice to a shared bus between chips, so that several slices behave as a single repeater. While any local source of traffic is present (a port receiving or colliding, the internal FIFO still draining, or a short fragment being padded to the 96-bit minimum), it pulls an active-low request line. An external arbiter answers with an active-low acknowledge and, when more than one slice is active, an active-low collision indication.

From the request and acknowledge combination the block chooses one of three bus roles: drive the shared data and jam lines, listen to them, or release both. Each role change happens on a 10 MHz bit-clock enable. When it drives, it puts NRZ repeat data on the data line. During a local collision it raises jam instead and uses the data line to say whether one local port or several are colliding. When it listens, it recovers the data or the remote collision type and flags which received bits count toward statistics. Only the synchronous bus mode is covered.

Top module: `exb_bus_ctrl`

## Requirements
- R1: While rst_ni is low, req_no is 1 and dat_oe_o, jam_oe_o, dat_o, jam_o, rx_valid_o, rx_bit_o, rmt_col_o, rmt_single_o, rx_stat_o and jam_gen_o are all 0.
- R2: On each clock edge with bit_en_i high, req_no becomes 0 if any bit of port_rx_i or port_col_i is set, or fifo_busy_i or frag_ext_i is high, and becomes 1 otherwise.
- R3: On a bit_en_i edge where req_no is 0 and ack_ni is 0, the block enters the drive role, with dat_oe_o and jam_oe_o both 1.
- R4: On a bit_en_i edge where ack_ni is 0 and req_no is 1, the block enters the listen role, with dat_oe_o and jam_oe_o both 0.
- R5: On a bit_en_i edge where ack_ni is 1, both output enables go to 0 and the block drives no data.
- R6: In the drive role with no bit of port_col_i set, jam_o is 0 and dat_o takes the value of tx_bit_i sampled at the same edge.
- R7: In the drive role with local collisions, jam_o is 1. dat_o is 1 when exactly one bit of port_col_i is set (single-port collision) and 0 when two or more are set (multiport collision).
- R8: On a bit_en_i edge while in the listen role with jam_i at 1, rmt_col_o becomes 1, rmt_single_o takes dat_i, and rx_valid_o becomes 0.
- R9: On a bit_en_i edge while in the listen role with jam_i at 0, rx_valid_o becomes 1 and rx_bit_o takes dat_i. Outside the listen role, all received outputs become 0.
- R10: rx_stat_o becomes 1 on an edge where rx_valid_o becomes 1 and mac_en_ni is 0. Otherwise it becomes 0.
- R11: On a bit_en_i edge, jam_gen_o becomes 1 when col_ni is 0 and req_no was 0 before the edge, and becomes 0 otherwise.
- R12: On clock edges with bit_en_i low, req_no and both output enables keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | 10 MHz bit-clock enable |
| port_rx_i | input | N_PORTS | Per-port receive activity |
| port_col_i | input | N_PORTS | Per-port collision activity |
| fifo_busy_i | input | 1 | Internal FIFO still draining |
| frag_ext_i | input | 1 | Fragment extension in progress |
| tx_bit_i | input | 1 | NRZ repeat bit to place on the bus |
| ack_ni | input | 1 | Arbiter acknowledge, active low |
| col_ni | input | 1 | Arbiter multi-slice collision, active low |
| mac_en_ni | input | 1 | Bus data counts toward statistics, active low |
| dat_i | input | 1 | Sampled shared data line |
| jam_i | input | 1 | Sampled shared jam line |
| req_no | output | 1 | Bus request, active low |
| dat_o | output | 1 | Data line drive value |
| dat_oe_o | output | 1 | Data line output enable |
| jam_o | output | 1 | Jam line drive value |
| jam_oe_o | output | 1 | Jam line output enable |
| rx_valid_o | output | 1 | Received data bit valid |
| rx_bit_o | output | 1 | Received data bit |
| rmt_col_o | output | 1 | Remote collision state seen |
| rmt_single_o | output | 1 | Remote collision is single-port |
| rx_stat_o | output | 1 | Received bit counts toward statistics |
| jam_gen_o | output | 1 | Generate the jam sequence locally |

## Verification
Two things can happen on the same bit. The local collision type can be encoded onto the driven lines while the arbiter also signals a collision between slices. The request can drop while the block is still driving, and the role must change only one bit later. Both cases are set up by single bench vectors. In one, two ports collide while col_ni is low. In the other, every activity source clears while acknowledge stays low. Each is judged against the full output set expected after that bit edge. Every check rests on the rule that a role is chosen from the request registered one bit earlier.

// File: rtl/exb_pkg.sv
`timescale 1ns/1ps
package exb_pkg;
  typedef enum logic [1:0] {
    XB_IDLE   = 2'd0,
    XB_DRIVE  = 2'd1,
    XB_LISTEN = 2'd2
  } xb_mode_e;

  typedef struct packed {
    logic valid;
    logic bit_v;
    logic rmt_col;
    logic rmt_single;
    logic stat;
  } xb_rx_t;
endpackage

// File: rtl/exb_activity.sv
`timescale 1ns/1ps
module exb_activity #(
  parameter int N_PORTS = 12,
  localparam int CNT_W = $clog2(N_PORTS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic [N_PORTS-1:0] port_rx_i,
  input  logic [N_PORTS-1:0] port_col_i,
  input  logic               fifo_busy_i,
  input  logic               frag_ext_i,
  output logic               req_q_o,
  output logic               col_any_o,
  output logic               col_single_o
);
  logic [CNT_W-1:0] col_cnt;
  logic             active;

  always_comb begin
    col_cnt = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      col_cnt = col_cnt + CNT_W'(port_col_i[i]);
    end
  end

  assign col_any_o    = (col_cnt != '0);
  assign col_single_o = (col_cnt == CNT_W'(1));
  assign active       = (|port_rx_i) | col_any_o | fifo_busy_i | frag_ext_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       req_q_o <= 1'b0;
    else if (bit_en_i) req_q_o <= active;
  end
endmodule

// File: rtl/exb_dir.sv
`timescale 1ns/1ps
module exb_dir
  import exb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bit_en_i,
  input  logic     req_q_i,
  input  logic     ack_ni,
  input  logic     col_any_i,
  input  logic     col_single_i,
  input  logic     tx_bit_i,
  output xb_mode_e mode_q_o,
  output logic     dat_o,
  output logic     jam_o,
  output logic     dat_oe_o,
  output logic     jam_oe_o
);
  xb_mode_e mode_d;
  logic     dat_d, jam_d;

  always_comb begin
    if (!ack_ni && req_q_i) mode_d = XB_DRIVE;
    else if (!ack_ni)       mode_d = XB_LISTEN;
    else                    mode_d = XB_IDLE;
  end

  // collision: jam high, data carries 1 = single port, 0 = multiport
  always_comb begin
    dat_d = 1'b0;
    jam_d = 1'b0;
    if (mode_d == XB_DRIVE) begin
      jam_d = col_any_i;
      dat_d = col_any_i ? col_single_i : tx_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o <= XB_IDLE;
      dat_o    <= 1'b0;
      jam_o    <= 1'b0;
      dat_oe_o <= 1'b0;
      jam_oe_o <= 1'b0;
    end else if (bit_en_i) begin
      mode_q_o <= mode_d;
      dat_o    <= dat_d;
      jam_o    <= jam_d;
      dat_oe_o <= (mode_d == XB_DRIVE);
      jam_oe_o <= (mode_d == XB_DRIVE);
    end
  end
endmodule

// File: rtl/exb_rx.sv
`timescale 1ns/1ps
module exb_rx
  import exb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     bit_en_i,
  input  xb_mode_e mode_q_i,
  input  logic     req_q_i,
  input  logic     dat_i,
  input  logic     jam_i,
  input  logic     mac_en_ni,
  input  logic     col_ni,
  output xb_rx_t   rx_q_o,
  output logic     jam_gen_o
);
  xb_rx_t rx_d;
  logic   listen;

  assign listen = (mode_q_i == XB_LISTEN);

  always_comb begin
    rx_d            = '0;
    rx_d.valid      = listen & ~jam_i;
    rx_d.bit_v      = listen & ~jam_i & dat_i;
    rx_d.rmt_col    = listen & jam_i;
    rx_d.rmt_single = listen & jam_i & dat_i;
    rx_d.stat       = listen & ~jam_i & ~mac_en_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q_o    <= '0;
      jam_gen_o <= 1'b0;
    end else if (bit_en_i) begin
      rx_q_o    <= rx_d;
      jam_gen_o <= req_q_i & ~col_ni;
    end
  end
endmodule

// File: rtl/exb_bus_ctrl.sv
`timescale 1ns/1ps
module exb_bus_ctrl
  import exb_pkg::*;
#(
  parameter int N_PORTS = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic [N_PORTS-1:0] port_rx_i,
  input  logic [N_PORTS-1:0] port_col_i,
  input  logic               fifo_busy_i,
  input  logic               frag_ext_i,
  input  logic               tx_bit_i,
  input  logic               ack_ni,
  input  logic               col_ni,
  input  logic               mac_en_ni,
  input  logic               dat_i,
  input  logic               jam_i,
  output logic               req_no,
  output logic               dat_o,
  output logic               dat_oe_o,
  output logic               jam_o,
  output logic               jam_oe_o,
  output logic               rx_valid_o,
  output logic               rx_bit_o,
  output logic               rmt_col_o,
  output logic               rmt_single_o,
  output logic               rx_stat_o,
  output logic               jam_gen_o
);
  logic     req_q, col_any, col_single;
  xb_mode_e mode_q;
  xb_rx_t   rx_q;

  exb_activity #(.N_PORTS(N_PORTS)) u_act (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .port_rx_i    (port_rx_i),
    .port_col_i   (port_col_i),
    .fifo_busy_i  (fifo_busy_i),
    .frag_ext_i   (frag_ext_i),
    .req_q_o      (req_q),
    .col_any_o    (col_any),
    .col_single_o (col_single)
  );

  exb_dir u_dir (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_en_i     (bit_en_i),
    .req_q_i      (req_q),
    .ack_ni       (ack_ni),
    .col_any_i    (col_any),
    .col_single_i (col_single),
    .tx_bit_i     (tx_bit_i),
    .mode_q_o     (mode_q),
    .dat_o        (dat_o),
    .jam_o        (jam_o),
    .dat_oe_o     (dat_oe_o),
    .jam_oe_o     (jam_oe_o)
  );

  exb_rx u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_en_i  (bit_en_i),
    .mode_q_i  (mode_q),
    .req_q_i   (req_q),
    .dat_i     (dat_i),
    .jam_i     (jam_i),
    .mac_en_ni (mac_en_ni),
    .col_ni    (col_ni),
    .rx_q_o    (rx_q),
    .jam_gen_o (jam_gen_o)
  );

  assign req_no       = ~req_q;
  assign rx_valid_o   = rx_q.valid;
  assign rx_bit_o     = rx_q.bit_v;
  assign rmt_col_o    = rx_q.rmt_col;
  assign rmt_single_o = rx_q.rmt_single;
  assign rx_stat_o    = rx_q.stat;
endmodule

// File: rtl/exb_bus_chk.sv
`timescale 1ns/1ps
module exb_bus_chk #(
  parameter int N_PORTS = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bit_en_i,
  input logic [N_PORTS-1:0] port_col_i,
  input logic               ack_ni,
  input logic               req_no,
  input logic               dat_o,
  input logic               jam_o,
  input logic               dat_oe_o,
  input logic               jam_oe_o,
  input logic               rx_valid_o,
  input logic               rmt_col_o,
  input logic               rx_stat_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(req_no)); // R12
  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(dat_oe_o) && $stable(jam_oe_o)); // R12
  AST_DRIVE_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !req_no && !ack_ni |=> dat_oe_o && jam_oe_o); // R3
  AST_LISTEN_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && req_no && !ack_ni |=> !dat_oe_o && !jam_oe_o); // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && ack_ni |=> !dat_oe_o && !jam_oe_o && !dat_o && !jam_o); // R5
  AST_COL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !req_no && !ack_ni && $countones(port_col_i) == 1 |=> jam_o && dat_o); // R7
  AST_COL_MULTI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && !req_no && !ack_ni && $countones(port_col_i) > 1 |=> jam_o && !dat_o); // R7
  AST_RX_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && rmt_col_o)); // R8
  AST_STAT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stat_o |-> rx_valid_o); // R10
endmodule

bind exb_bus_ctrl exb_bus_chk #(.N_PORTS(N_PORTS)) u_chk (.*);

// File: tb/tb_exb_bus_ctrl.sv
`timescale 1ns/1ps
module tb_exb_bus_ctrl;
  localparam int NP = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en = 1'b0;
  logic [NP-1:0] prx = '0, pcol = '0;
  logic          fifo = 1'b0, frag = 1'b0, tx = 1'b0;
  logic          ack_n = 1'b1, col_n = 1'b1, mac_n = 1'b1, din = 1'b0, jin = 1'b0;
  logic req_n, dout, doe, jout, joe, rv, rb, rc, rs, st, jg;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  exb_bus_ctrl #(.N_PORTS(NP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en),
    .port_rx_i(prx), .port_col_i(pcol), .fifo_busy_i(fifo), .frag_ext_i(frag),
    .tx_bit_i(tx), .ack_ni(ack_n), .col_ni(col_n), .mac_en_ni(mac_n),
    .dat_i(din), .jam_i(jin),
    .req_no(req_n), .dat_o(dout), .dat_oe_o(doe), .jam_o(jout), .jam_oe_o(joe),
    .rx_valid_o(rv), .rx_bit_o(rb), .rmt_col_o(rc), .rmt_single_o(rs),
    .rx_stat_o(st), .jam_gen_o(jg)
  );

  // exp = {req_no, dat_oe, jam_oe, dat_o, jam_o, rx_valid, rx_bit, rmt_col, rmt_single, rx_stat, jam_gen}
  typedef struct packed {
    logic [NP-1:0] rx;
    logic [NP-1:0] col;
    logic fifo, frag, tx, ack_n, col_n, mac_n, d, j;
    logic [10:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{12'h000, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 11'b1_00_00_00000_0}, // R2 idle
    '{12'h001, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 11'b0_00_00_00000_0}, // R2 R5
    '{12'h001, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'b0_11_10_00000_0}, // R3 R6
    '{12'h001, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'b0_11_00_00000_0}, // R6
    '{12'h003, 12'h002, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'b0_11_11_00000_0}, // R7 single
    '{12'h000, 12'h006, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'b0_11_01_00000_1}, // R7 multi + R11
    '{12'h000, 12'h000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'b0_11_10_00000_0}, // R2 fifo
    '{12'h000, 12'h000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'b0_11_00_00000_0}, // R2 frag
    '{12'h000, 12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'b1_11_10_00000_0}, // R3 role lags request
    '{12'h000, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'b1_00_00_00000_0}, // R4
    '{12'h000, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 11'b1_00_00_11000_0}, // R9
    '{12'h000, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'b1_00_00_10001_0}, // R9 R10
    '{12'h000, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 11'b1_00_00_00110_0}, // R8 single
    '{12'h000, 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 11'b1_00_00_00100_0}, // R8 multi
    '{12'h000, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 11'b1_00_00_11001_0}, // R5 R10
    '{12'h000, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 11'b1_00_00_00000_0}, // R9 idle
    '{12'h000, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'b1_00_00_00000_0}, // R11 no request
    '{12'h001, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'b0_00_00_00000_0}, // R11 request not yet seen
    '{12'h001, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'b0_00_00_00000_1}  // R11
  };

  function automatic logic [10:0] outs();
    return {req_n, doe, joe, dout, jout, rv, rb, rc, rs, st, jg};
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    prx = v.rx; pcol = v.col; fifo = v.fifo; frag = v.frag; tx = v.tx;
    ack_n = v.ack_n; col_n = v.col_n; mac_n = v.mac_n; din = v.d; jin = v.j;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog all requirements actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", outs(), 11'b1_00_00_00000_0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: no bit enable, active inputs and grant must not change request or enables
    prx = 12'h001; ack_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 hold without bit enable", outs(), 11'b1_00_00_00000_0);
    prx = '0; ack_n = 1'b1;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;

    for (int k = 0; k < NV; k++) begin
      apply(VECS[k]);
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      check($sformatf("vector %0d", k), outs(), VECS[k].exp);
      @(negedge clk);
      check($sformatf("R12 vector %0d hold", k), {outs()}, VECS[k].exp);
    end

    // R1: asynchronous reset in the middle of a driven bit
    prx = 12'h001; ack_n = 1'b0; tx = 1'b1; col_n = 1'b1;
    repeat (2) begin
      bit_en = 1'b1; @(negedge clk); bit_en = 1'b0;
    end
    check("R3 driving before reset", outs(), 11'b0_11_10_00000_0);
    #2 rst_n = 1'b0;
    #1 check("R1 async reset", outs(), 11'b1_00_00_00000_0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule